// File: doc/BRIEF.md
# Inverted Serial Servo Frame Sender

This block keeps a radio-control style servo bus fed without any help from a processor. Software writes sixteen 11-bit channel positions, a flag byte and a command word into a small register file over a simple write port. Once transmission is enabled, the block sends a 25-character frame on a single line again and again, with an idle gap between frames. Each frame is a header character, 22 characters that carry the channel bits packed end to end, the flag character and a trailer character.

Each character goes out through a UART-style shift register. The character has a start bit, eight data bits with the most significant bit first, an even parity bit and two stop bits. By default the line is driven inverted, so it idles low. A command bit selects the plain polarity for receivers that need it. At the first character of each frame, the channel and flag values are captured, so a write made while a frame is on the line only shows up in the next frame. The command word is read again while the trailer character is on the line, and the new polarity is applied in the gap that follows.

Top module: `servo_frame_tx`

## Requirements
- R1: Every character is 12 bit periods of BIT_CYCLES clocks each. Before the polarity step, the start bit is 0, the data bits go out bit 7 first, the parity bit equals the XOR of the eight data bits (even parity), and both stop bits are 1.
- R2: A frame is 25 characters in this order: 0x0F, 22 channel-data characters, the low 8 bits of the flag register, then 0x00.
- R3: Channel c bit k sits at position 11*c+k of a 176-bit stream. Bit b of data character j (counting from 0) carries stream bit 8*j+b.
- R4: The write port decodes addresses 0 to 15 as channels 0 to 15, address 16 as the flag register and address 17 as the command register. Data bits above each register's width are ignored, and writes to addresses 18 to 31 change nothing.
- R5: After reset the command register is 0: nothing is sent and the line rests at the inverted idle level (low). No frame starts while command bit 0 (enable) is 0.
- R6: Command bit 1 = 0 drives the line inverted (idle low). Bit 1 = 1 drives it plain (idle high). A polarity change made while frames are running is read during the trailer character of the next frame and holds from the gap after that frame.
- R7: While enabled, frames repeat with no further writes, and the line stays at idle level for at least GAP_BITS bit periods between the end of one frame and the start bit of the next.
- R8: A channel or flag write made while a frame is being sent leaves that frame unchanged and appears in the following frame.
- R9: When enable is cleared while frames are running, the frame in progress and the frame whose trailer character reads the cleared bit are still sent. After that no frame starts, and the line keeps the idle level of the current command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register address of the write |
| wrData | input | 32 | Write data; only the low bits of the target register are kept |
| txLine | output | 1 | Serial servo line |

## Verification
The in-line assertions watch four things on every cycle. Each character must start with a 0 bit. Nothing but a 1 may leave the shift register between frames. Polarity and the captured frame contents must stay fixed while a frame is on the line. A frame may start only when the pending enable is set. Other behaviour can only be shown by the bench's scenarios: the exact character values and bit packing, the frame order, the one-frame delay of mid-frame writes, the two-frame delay of a polarity change and the stop after enable is cleared. The bench decodes the line the way a receiver would and compares each character with a queue of values built from the register writes.

// File: rtl/svtx_pkg.sv
package svtx_pkg;

  // framing constants of the servo bus
  localparam logic [7:0] HEAD_BYTE = 8'h0F;
  localparam logic [7:0] TAIL_BYTE = 8'h00;
  localparam int CHAR_BITS = 12;

  // control -> datapath strobes
  typedef struct packed {
    logic snapFrame;   // capture channels and flags for a new frame
    logic readCfg;     // sample command register into pending config
    logic applyCfg;    // move pending polarity onto the line
    logic loadChar;    // load a new character into the shifter
    logic shiftBit;    // advance the shifter by one bit
    logic busy;        // a frame is on the line
  } txStrobes_t;

endpackage

// File: rtl/svtx_datapath.sv
module svtx_datapath
  import svtx_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int CH_BITS = 11,
  parameter int ADDR_W  = 5,
  parameter int BYTE_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  txStrobes_t        strb,
  input  logic [BYTE_W-1:0] byteSel,
  output logic              pendEn,
  output logic              txLine
);

  localparam int PAY_BITS   = NUM_CH * CH_BITS;
  localparam int DATA_BYTES = (PAY_BITS + 7) / 8;
  localparam int FLAT_W     = DATA_BYTES * 8;
  localparam int FLAG_ADDR  = NUM_CH;
  localparam int CMD_ADDR   = NUM_CH + 1;

  logic [CH_BITS-1:0] chanReg [NUM_CH];
  logic [7:0]         flagReg;
  logic [1:0]         cmdReg;
  logic [FLAT_W-1:0]  liveFlat;
  logic [FLAT_W-1:0]  snapFlat;
  logic [7:0]         snapFlags;
  logic               pendInv;
  logic               lineInv;
  logic [7:0]         curByte;
  logic [CHAR_BITS-1:0] shReg;
  logic               unusedHiBits;

  assign unusedHiBits = ^wrData[31:CH_BITS];

  // channel registers and stream packing
  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    always_ff @(posedge clk) begin
      if (!rstN)                                   chanReg[c] <= '0;
      else if (wrEn && wrAddr == ADDR_W'(c))       chanReg[c] <= wrData[CH_BITS-1:0];
    end
    assign liveFlat[c*CH_BITS +: CH_BITS] = chanReg[c];
  end
  if (FLAT_W > PAY_BITS) begin : gPad
    assign liveFlat[FLAT_W-1:PAY_BITS] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagReg <= '0;
      cmdReg  <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_W'(FLAG_ADDR)) flagReg <= wrData[7:0];
      if (wrAddr == ADDR_W'(CMD_ADDR))  cmdReg  <= wrData[1:0];
    end
  end

  // frame capture and configuration staging
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapFlat  <= '0;
      snapFlags <= '0;
      pendEn    <= 1'b0;
      pendInv   <= 1'b1;
      lineInv   <= 1'b1;
    end else begin
      if (strb.snapFrame) begin
        snapFlat  <= liveFlat;
        snapFlags <= flagReg;
      end
      if (strb.readCfg) begin
        pendEn  <= cmdReg[0];
        pendInv <= ~cmdReg[1];
      end
      if (strb.applyCfg) lineInv <= pendInv;
    end
  end

  // character selection
  always_comb begin
    curByte = TAIL_BYTE;
    if (byteSel == '0) curByte = HEAD_BYTE;
    for (int j = 0; j < DATA_BYTES; j++)
      if (byteSel == BYTE_W'(j + 1)) curByte = snapFlat[8*j +: 8];
    if (byteSel == BYTE_W'(DATA_BYTES + 1)) curByte = snapFlags;
  end

  // UART shifter, shifts ones in so it rests at the idle level
  always_ff @(posedge clk) begin
    if (!rstN)              shReg <= '1;
    else if (strb.loadChar) shReg <= {1'b0, curByte, ^curByte, 2'b11};
    else if (strb.shiftBit) shReg <= {shReg[CHAR_BITS-2:0], 1'b1};
  end

  assign txLine = shReg[CHAR_BITS-1] ^ lineInv;

  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadChar |=> (shReg[CHAR_BITS-1] == 1'b0))
    else $error("start bit not low after character load");

  // R1
  idle_raw_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.busy |-> shReg[CHAR_BITS-1])
    else $error("shifter not at idle level outside a frame");

  // R6
  polarity_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && $past(strb.busy)) |-> $stable(lineInv))
    else $error("polarity changed inside a frame");

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && $past(strb.busy)) |-> ($stable(snapFlat) && $stable(snapFlags)))
    else $error("captured frame changed while sending");

endmodule

// File: rtl/svtx_ctrl.sv
module svtx_ctrl
  import svtx_pkg::*;
#(
  parameter int BIT_CYCLES  = 1250,
  parameter int GAP_BITS    = 300,
  parameter int FRAME_BYTES = 25,
  parameter int BYTE_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pendEn,
  output txStrobes_t        strb,
  output logic [BYTE_W-1:0] byteSel
);

  localparam int GAP_CYC = GAP_BITS * BIT_CYCLES;
  localparam int CNT_W   = $clog2(BIT_CYCLES + 1);
  localparam int GAP_W   = $clog2(GAP_CYC + 1);
  localparam int IDX_W   = $clog2(CHAR_BITS);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} txState_e;

  txState_e          state;
  logic [CNT_W-1:0]  bitCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [BYTE_W-1:0] byteIdx;
  logic [GAP_W-1:0]  gapCnt;
  logic bitEnd, charEnd, lastByte, gapEnd;

  assign bitEnd   = (bitCnt == CNT_W'(BIT_CYCLES - 1));
  assign charEnd  = bitEnd && (bitIdx == IDX_W'(CHAR_BITS - 1));
  assign lastByte = (byteIdx == BYTE_W'(FRAME_BYTES - 1));
  assign gapEnd   = (gapCnt == GAP_W'(GAP_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      bitIdx  <= '0;
      byteIdx <= '0;
      gapCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          bitCnt  <= '0;
          bitIdx  <= '0;
          byteIdx <= '0;
          if (pendEn) state <= ST_SEND;
        end
        ST_SEND: begin
          bitCnt <= bitEnd ? '0 : bitCnt + 1'b1;
          if (bitEnd) bitIdx <= charEnd ? '0 : bitIdx + 1'b1;
          if (charEnd) begin
            if (lastByte) begin
              state   <= ST_GAP;
              gapCnt  <= '0;
              byteIdx <= '0;
            end else begin
              byteIdx <= byteIdx + 1'b1;
            end
          end
        end
        ST_GAP: begin
          gapCnt <= gapCnt + 1'b1;
          if (gapEnd) state <= pendEn ? ST_SEND : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.busy      = (state == ST_SEND);
    strb.snapFrame = pendEn && ((state == ST_IDLE) || (state == ST_GAP && gapEnd));
    strb.readCfg   = (state == ST_IDLE) ||
                     (strb.busy && lastByte && bitIdx == '0 && bitCnt == '0);
    strb.applyCfg  = !strb.busy;
    strb.loadChar  = strb.busy && bitCnt == '0 && bitIdx == '0;
    strb.shiftBit  = strb.busy && bitCnt == '0 && bitIdx != '0;
  end

  assign byteSel = byteIdx;

  // R5
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.busy) |-> $past(pendEn))
    else $error("frame started without pending enable");

endmodule

// File: rtl/servo_frame_tx.sv
module servo_frame_tx
  import svtx_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int CH_BITS    = 11,
  parameter int ADDR_W     = 5,
  parameter int BIT_CYCLES = 1250,
  parameter int GAP_BITS   = 300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  output logic              txLine
);

  localparam int FRAME_BYTES = (NUM_CH * CH_BITS + 7) / 8 + 3;
  localparam int BYTE_W      = $clog2(FRAME_BYTES);

  txStrobes_t        strb;
  logic [BYTE_W-1:0] byteSel;
  logic              pendEn;

  svtx_ctrl #(
    .BIT_CYCLES(BIT_CYCLES), .GAP_BITS(GAP_BITS),
    .FRAME_BYTES(FRAME_BYTES), .BYTE_W(BYTE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pendEn(pendEn), .strb(strb), .byteSel(byteSel)
  );

  svtx_datapath #(
    .NUM_CH(NUM_CH), .CH_BITS(CH_BITS), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .byteSel(byteSel), .pendEn(pendEn), .txLine(txLine)
  );

endmodule

// File: tb/servo_frame_tx_bench.sv
module servo_frame_tx_bench;

  localparam int BITC = 8;
  localparam int GAPB = 12;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic txLine;

  int tests = 0;
  int fails = 0;
  int frameCount = 0;
  bit expInv = 1'b1;
  bit monOff = 1'b0;
  item_t expQ[$];
  logic [10:0] chanM [16];
  logic [7:0] flagM;

  always #4 clk = ~clk;

  servo_frame_tx #(.BIT_CYCLES(BITC), .GAP_BITS(GAPB)) u_servo_frame_tx (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txLine(txLine)
  );

  function automatic logic idleLvl();
    return expInv ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    wrEn = 1'b1; wrAddr = 5'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pushFrame(input string tag);
    item_t it;
    it.val = 8'h0F; it.tag = "R2"; expQ.push_back(it);
    for (int j = 0; j < 22; j++) begin
      logic [7:0] v;
      for (int b = 0; b < 8; b++) begin
        int idx = 8 * j + b;
        v[b] = chanM[idx / 11][idx % 11];
      end
      it.val = v; it.tag = tag; expQ.push_back(it);
    end
    it.val = flagM; it.tag = "R2"; expQ.push_back(it);
    it.val = 8'h00; it.tag = "R2"; expQ.push_back(it);
  endtask

  // monitor: receiver-style decoder feeding the scoreboard
  initial begin : monitor
    item_t e;
    logic [11:0] raw;
    logic [7:0] data;
    int run;
    int pos = 0;
    bit prevInv = 1'b1;
    @(posedge rstN);
    @(negedge clk);
    forever begin
      while (monOff || txLine !== idleLvl()) @(negedge clk);
      run = 0;
      while (monOff || txLine === idleLvl()) begin run++; @(negedge clk); end
      repeat (BITC / 2) @(negedge clk);
      raw[11] = txLine ^ expInv;
      for (int k = 10; k >= 0; k--) begin
        repeat (BITC) @(negedge clk);
        raw[k] = txLine ^ expInv;
      end
      data = raw[10:3];
      chk(raw[11] == 1'b0 && raw[2] == ^data && raw[1:0] == 2'b11, "R1",
          "character framing", int'(raw), int'({1'b0, data, ^data, 2'b11}));
      if (pos == 0 && frameCount > 0 && prevInv == expInv)
        chk(run >= GAPB * BITC, "R7", "idle gap cycles", run, GAPB * BITC);
      if (expQ.size() == 0) begin
        chk(1'b0, "R9", "unexpected character", int'(data), 0);
      end else begin
        e = expQ.pop_front();
        chk(data == e.val, e.tag, "character value", int'(data), int'(e.val));
      end
      prevInv = expInv;
      pos++;
      if (pos == 25) begin
        pos = 0;
        frameCount++;
        @(negedge clk);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // driver
  initial begin
    int stray;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R5: reset idle level is inverted low
    chk(txLine == 1'b0, "R5", "reset line level", int'(txLine), 0);

    for (int c = 0; c < 16; c++) begin
      chanM[c] = 11'((c * 137 + 5) & 'h7FF);
      wr(c, 32'hABC0_0800 | 32'(chanM[c]));   // R4 upper bits must be dropped
    end
    flagM = 8'h35;
    wr(16, 32'hFFFF_FF35);
    wr(20, 32'hFFFF_FFFF);                     // R4 unmapped address
    stray = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (txLine !== 1'b0) stray++;
    end
    chk(stray == 0, "R5", "activity while disabled", stray, 0);

    pushFrame("R4");
    wr(17, 32'h0000_0001);

    wait (frameCount == 1);
    pushFrame("R7");                           // resent with no writes

    wait (frameCount == 2);
    pushFrame("R3");
    repeat (1000) @(negedge clk);              // inside frame 3
    chanM[0] = 11'h7FF;
    flagM = 8'h0C;
    wr(0, 32'h0000_07FF);
    wr(16, 32'h0000_000C);
    pushFrame("R8");                           // frame 4 carries the update

    wait (frameCount == 4);
    for (int c = 0; c < 16; c++) begin
      chanM[c] = 11'((c * 'h93) ^ 'h6A5);
      wr(c, 32'(chanM[c]));
    end
    wr(17, 32'h0000_0003);                     // R6 plain polarity requested
    pushFrame("R6");                           // frame 5 still inverted

    wait (frameCount == 5);
    expInv = 1'b0;
    pushFrame("R6");                           // frame 6 plain

    wait (frameCount == 6);
    wr(17, 32'h0000_0002);                     // R9 disable
    pushFrame("R9");

    wait (frameCount == 7);
    repeat (7500) @(negedge clk);
    chk(frameCount == 7, "R9", "frames after disable", frameCount, 7);
    chk(txLine == 1'b1, "R6", "plain idle level", int'(txLine), 1);
    chk(expQ.size() == 0, "R7", "expected characters left", expQ.size(), 0);

    monOff = 1'b1;
    wr(17, 32'h0000_0000);
    repeat (5) @(negedge clk);
    chk(txLine == 1'b0, "R6", "inverted idle level after command", int'(txLine), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule